// File: doc/BRIEF.md
# Drum Fill-Stir-Drain Sequencer

A three-bit synchronous controller that sequences a mixing drum through five phases: idle, filling, filling while stirring, stirring alone, and draining. Each of its three state bits drives one actuator directly. The pump is the high bit, the stirring motor is the middle bit and the drain valve is the low bit. A 1 on an output switches that device on. All three bits load from one common clock. The state moves forward by one phase in each clock cycle where the step tick is high, so every phase lasts exactly one step period.

The next-state equations were chosen by giving values to the three codes the sequence never uses. Those codes are then checked so that each one joins the main loop after a single step, and none of them can trap the controller. A start-process request passes through a synchronizer and then drives the state to idle, so that each run begins from a known phase. The register's power-up value is a parameter. This allows the block to be started from any code, including the unused ones.

Top module: `drum_seq`

## Requirements
- R1: With step_tick at 1 and no start request active, the outputs (pump, motor, valve) advance 000 → 100 → 110 → 010 → 001 → 000, one transition per clock edge.
- R2: With step_tick at 0 and no synchronized start request, all three outputs hold their values at the clock edge.
- R3: start_req passes through a two-flop synchronizer. When it goes to 1, the outputs read 000 after the third rising edge. While the synchronized request is 1 it overrides step_tick.
- R4: The unused codes move in one step as 011 → 001, 101 → 010 and 111 → 010.
- R5: After any edge that applied a step or a synchronized start, pump_on and valve_open are never both 1.
- R6: Before the first clock edge, the outputs equal the POWERUP_CODE parameter, with bit 2 on pump_on, bit 1 on motor_on and bit 0 on valve_open.
- R7: While start_req is held at 1, the outputs stay at 000 whatever step_tick does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all state bits |
| step_tick | input | 1 | Advance enable, one phase per cycle in which it is high |
| start_req | input | 1 | Asynchronous start-process request that forces the idle phase |
| pump_on | output | 1 | Fill pump drive (state bit 2) |
| motor_on | output | 1 | Stirring motor drive (state bit 1) |
| valve_open | output | 1 | Drain valve drive (state bit 0) |

## Verification
The assertions check on every cycle that the state holds when no step is applied, that a synchronized start leaves the state idle, and that each synchronizer stage copies the stage before it. They also check two arcs of the main loop, that an unused code returns to the loop in one step, and that the pump and valve are never on together after an update. Only the bench scenarios can show the power-up code of each of the eight instances, the exact two-cycle latency of a start request as seen from the input pin, and a start request overriding a step over long random runs. The bench starts one instance from each code, drives all eight together and compares them against its own model.

// File: rtl/drum_seq_pkg.sv
package drum_seq_pkg;
  localparam int CODE_W    = 3;
  localparam int PUMP_BIT  = 2;
  localparam int MOTOR_BIT = 1;
  localparam int VALVE_BIT = 0;

  typedef logic [CODE_W-1:0] drum_code_t;

  localparam drum_code_t CODE_IDLE  = 3'b000;
  localparam drum_code_t CODE_FILL  = 3'b100;
  localparam drum_code_t CODE_MIXF  = 3'b110;
  localparam drum_code_t CODE_STIR  = 3'b010;
  localparam drum_code_t CODE_DRAIN = 3'b001;

  // Next phase: pump follows "motor and valve both off", motor follows pump,
  // valve opens when the motor runs without the pump.
  function automatic drum_code_t seq_next(input drum_code_t cur);
    drum_code_t nxt;
    nxt[PUMP_BIT]  = ~cur[MOTOR_BIT] & ~cur[VALVE_BIT];
    nxt[MOTOR_BIT] = cur[PUMP_BIT];
    nxt[VALVE_BIT] = ~cur[PUMP_BIT] & cur[MOTOR_BIT];
    return nxt;
  endfunction

  function automatic logic in_main_loop(input drum_code_t c);
    return (c == CODE_IDLE) || (c == CODE_FILL) || (c == CODE_MIXF) ||
           (c == CODE_STIR) || (c == CODE_DRAIN);
  endfunction
endpackage

// File: rtl/drum_seq_sync.sv
module drum_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q = '0;
  logic              armed_q = 1'b0;

  always_ff @(posedge clk) armed_q <= 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) chain_q[0] <= async_in;
    end else begin : g_rest
      always_ff @(posedge clk) chain_q[i] <= chain_q[i-1];
      // R3: each stage copies its predecessor one edge later
      p_stage_shift_r3: assert property (@(posedge clk) disable iff (!armed_q)
        chain_q[i] == $past(chain_q[i-1]));
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/drum_seq_next.sv
module drum_seq_next
  import drum_seq_pkg::*;
(
  input  drum_code_t cur_code,
  output drum_code_t nxt_code,
  output logic       cur_in_loop
);
  assign nxt_code    = seq_next(cur_code);
  assign cur_in_loop = in_main_loop(cur_code);
endmodule

// File: rtl/drum_seq_reg.sv
module drum_seq_reg
  import drum_seq_pkg::*;
#(
  parameter drum_code_t INIT_CODE = CODE_IDLE
) (
  input  logic       clk,
  input  logic       advance,
  input  logic       clear,
  input  drum_code_t d_next,
  output drum_code_t q
);
  drum_code_t state_q = INIT_CODE;
  logic       armed_q = 1'b0;

  always_ff @(posedge clk) begin
    armed_q <= 1'b1;
    if (clear)        state_q <= CODE_IDLE;
    else if (advance) state_q <= d_next;
  end

  assign q = state_q;

  // R2: no update requested, no change
  p_hold_no_step_r2: assert property (@(posedge clk) disable iff (!armed_q)
    (!$past(clear) && !$past(advance)) |-> $stable(state_q));
  // R3: synchronized start lands in idle
  p_clear_idle_r3: assert property (@(posedge clk) disable iff (!armed_q)
    $past(clear) |-> (state_q == CODE_IDLE));
  // R5: pump and valve never both on after an update
  p_pump_valve_excl_r5: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(clear) || $past(advance)) |-> !(state_q[PUMP_BIT] && state_q[VALVE_BIT]));
endmodule

// File: rtl/drum_seq.sv
module drum_seq
  import drum_seq_pkg::*;
#(
  parameter drum_code_t POWERUP_CODE = CODE_IDLE,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic step_tick,
  input  logic start_req,
  output logic pump_on,
  output logic motor_on,
  output logic valve_open
);
  logic       start_sync;
  drum_code_t cur_code;
  drum_code_t nxt_code;
  logic       cur_in_loop;
  logic       armed_q = 1'b0;

  always_ff @(posedge clk) armed_q <= 1'b1;

  drum_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in (start_req),
    .sync_out (start_sync)
  );

  drum_seq_next u_next (
    .cur_code    (cur_code),
    .nxt_code    (nxt_code),
    .cur_in_loop (cur_in_loop)
  );

  drum_seq_reg #(.INIT_CODE(POWERUP_CODE)) u_reg (
    .clk     (clk),
    .advance (step_tick),
    .clear   (start_sync),
    .d_next  (nxt_code),
    .q       (cur_code)
  );

  assign pump_on    = cur_code[PUMP_BIT];
  assign motor_on   = cur_code[MOTOR_BIT];
  assign valve_open = cur_code[VALVE_BIT];

  // R4: an unused code rejoins the loop after one step
  p_unused_recover_r4: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(step_tick) && !$past(start_sync) && !$past(cur_in_loop)) |-> cur_in_loop);
  // R1: fill goes to fill-and-stir
  p_fill_to_mix_r1: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(step_tick) && !$past(start_sync) && $past(cur_code) == CODE_FILL)
      |-> (cur_code == CODE_MIXF));
  // R1: stir-only goes to drain
  p_stir_to_drain_r1: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(step_tick) && !$past(start_sync) && $past(cur_code) == CODE_STIR)
      |-> (cur_code == CODE_DRAIN));
endmodule

// File: tb/drum_seq_bench.sv
module drum_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NINST      = 8;

  logic clk = 1'b0;
  logic step = 1'b0;
  logic start = 1'b0;
  logic [NINST-1:0] pump, motor, valve;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] exp_q [NINST];
  logic       m_s1 = 1'b0, m_s2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NINST; g++) begin : g_code
    drum_seq #(.POWERUP_CODE(3'(g))) u_drum_seq (
      .clk        (clk),
      .step_tick  (step),
      .start_req  (start),
      .pump_on    (pump[g]),
      .motor_on   (motor[g]),
      .valve_open (valve[g])
    );
  end

  // Transition table written from R1 and R4
  function automatic logic [2:0] ref_next(input logic [2:0] c);
    case (c)
      3'b000: return 3'b100;
      3'b100: return 3'b110;
      3'b110: return 3'b010;
      3'b010: return 3'b001;
      3'b001: return 3'b000;
      3'b011: return 3'b001;
      3'b101: return 3'b010;
      default: return 3'b010; // 111
    endcase
  endfunction

  task automatic check_all(input string req);
    for (int g = 0; g < NINST; g++) begin
      logic [2:0] obs;
      obs = {pump[g], motor[g], valve[g]};
      checks++;
      if (obs !== exp_q[g]) begin
        errors++;
        $display("FAIL %s inst %0d: got %b expected %b", req, g, obs, exp_q[g]);
      end
      if ($time > CLK_PERIOD && pump[g] && valve[g] && exp_q[g] != 3'b101 && exp_q[g] != 3'b111) begin
        checks++; errors++;
        $display("FAIL R5 inst %0d: got pump=1 valve=1 expected not both", g);
      end
    end
  endtask

  // Apply inputs at a falling edge, advance model at the rising edge, check at next falling edge
  task automatic cycle(input logic st, input logic sp, input string req);
    step = st;
    start = sp;
    @(posedge clk);
    for (int g = 0; g < NINST; g++)
      exp_q[g] = m_s2 ? 3'b000 : (st ? ref_next(exp_q[g]) : exp_q[g]);
    m_s2 = m_s1;
    m_s1 = sp;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int g = 0; g < NINST; g++) exp_q[g] = 3'(g);
    #2;
    check_all("R6 powerup");

    @(negedge clk);
    cycle(1'b1, 1'b0, "R1/R4 first step from each code");
    for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, "R1 main loop");
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, "R2 hold");

    // start latency and priority over step
    cycle(1'b1, 1'b1, "R3 start latency 1");
    cycle(1'b1, 1'b1, "R3 start latency 2");
    cycle(1'b1, 1'b1, "R3 start forces idle");
    for (int k = 0; k < 6; k++) cycle(k[0], 1'b1, "R7 start held");
    cycle(1'b1, 1'b0, "R3 release pipeline");
    cycle(1'b1, 1'b0, "R3 release pipeline");
    cycle(1'b1, 1'b0, "R1 fill after start");

    for (int k = 0; k < 600; k++) begin
      logic st, sp;
      st = ($urandom % 2) == 0;
      sp = ($urandom % 20) == 0;
      if (m_s2)       cycle(st, sp, "R3 random start");
      else if (st)    cycle(st, sp, "R1 R4 random step");
      else            cycle(st, sp, "R2 random hold");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule